// File: doc/BRIEF.md
# Two-Base Delta Cache Line Codec

This block shrinks 256-bit cache lines for storage and expands them again. A line is handled as eight 32-bit words. The compressor tries to describe every word as a signed 8-bit delta from one of two bases. One base is the line's own lowest word. The other base is a fixed zero. If every word can be described this way, the compressor emits a 96-bit packed form and an 8-bit base-select mask, and it raises a packed flag. If any word cannot be described, the line goes through unchanged with the flag low.

The expander takes that same triple (data, mask, flag) and rebuilds all eight words in parallel. For each word it adds the sign-extended delta to the base chosen by the mask. When the flag is low it returns the data untouched.

Both directions are valid/ready streams. Each pipeline slot is a small two-state machine. The states are `SLOT_EMPTY` and `SLOT_FULL`, and the transitions are:
- fill: EMPTY to FULL on an accepted transfer.
- drain: FULL to EMPTY when the slot hands its item on and nothing replaces it.
- refill: FULL stays FULL when it hands its item on and takes a new one in the same cycle.
- hold: FULL stays FULL while the downstream side is stalled.

The compressor has two such slots in series: a classify stage and an output stage. The expander has one slot.

Top module: `bdi_line_codec`

## Requirements
- R1: Word i is bits [32i+31:32i] of a line. A word fits the line base if (word − word0), taken modulo 2^32, lies in −128..+127 as a signed value. A word fits the zero base if the word itself, read as signed, lies in −128..+127.
- R2: When a word fits the zero base, its mask bit (bit i of `c_out_mask`) is 1 and its delta is the word's low byte, even if it also fits the line base. Otherwise the mask bit is 0 and the delta is the low byte of (word − word0).
- R3: On a packed result (`c_out_packed`=1), `c_out_data` holds word0 in bits [31:0] and delta i in bits [32+8i+7:32+8i]. Bits [255:96] are zero.
- R4: If any word fits neither base, `c_out_packed` is 0, `c_out_data` equals the input line exactly, and `c_out_mask` is 0.
- R5: A line of all-zero words packs with mask 8'hFF and zero deltas. A line of one repeated value outside −128..127 packs with mask 8'h00 and zero deltas.
- R6: With the output ready and the compressor empty, a line accepted at a clock edge appears on `c_out_valid` two edges later.
- R7: With `d_in_packed`=1, output word i is sext(delta i) when mask bit i is 1, and word0 + sext(delta i) (modulo 2^32) when it is 0. The word0 value comes from `d_in_data` bits [31:0].
- R8: With `d_in_packed`=0, `d_out_line` equals `d_in_data`. The mask has no effect.
- R9: With the output ready and the expander empty, an item accepted at an edge appears on `d_out_valid` one edge later.
- R10: While an output is valid and not ready, it holds its valid and its values. Every accepted item leaves exactly once, in order.
- R11: During reset, both outputs are not valid and both input readies are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| c_in_valid | input | 1 | Compressor input line valid |
| c_in_ready | output | 1 | Compressor can accept a line |
| c_in_line | input | 256 | Line to compress |
| c_out_valid | output | 1 | Compressor result valid |
| c_out_ready | input | 1 | Consumer takes the compressor result |
| c_out_data | output | 256 | Packed form or raw line |
| c_out_mask | output | 8 | Per-word zero-base select |
| c_out_packed | output | 1 | 1 when the line was packed |
| d_in_valid | input | 1 | Expander input valid |
| d_in_ready | output | 1 | Expander can accept an item |
| d_in_data | input | 256 | Packed form or raw line |
| d_in_mask | input | 8 | Per-word zero-base select |
| d_in_packed | input | 1 | 1 when the data is packed |
| d_out_valid | output | 1 | Rebuilt line valid |
| d_out_ready | input | 1 | Consumer takes the rebuilt line |
| d_out_line | output | 256 | Rebuilt 256-bit line |

## Verification
A compressed result is due two edges after its line is accepted, and a rebuilt line is due one edge after acceptance. This holds only while the output side stays ready and the path is empty. Directed items are sent into an idle path with the ready held high. They carry the cycle of acceptance, and the scoreboard compares this with the cycle the result is taken, expecting a gap of exactly 2 or 1. Under randomly toggled ready, timing is not checked. Instead the scoreboard checks values and order only, so stalls may stretch the delay without counting as errors.

// File: rtl/bdi_pkg.sv
package bdi_pkg;
    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_t;
endpackage

// File: rtl/bdi_fit_check.sv
module bdi_fit_check #(
    parameter int WORD_W  = 32,
    parameter int DELTA_W = 8
) (
    input  logic [WORD_W-1:0]  word,
    input  logic [WORD_W-1:0]  base,
    output logic               use_zero,
    output logic               fits_any,
    output logic [DELTA_W-1:0] delta
);
    localparam int HI_W = WORD_W - DELTA_W + 1;

    logic [WORD_W-1:0] diff;
    logic [HI_W-1:0]   z_top;
    logic [HI_W-1:0]   b_top;
    logic              z_ok;
    logic              b_ok;

    always_comb begin
        diff  = word - base;
        z_top = word[WORD_W-1:DELTA_W-1];
        b_top = diff[WORD_W-1:DELTA_W-1];
        // a value fits when its upper bits are a pure sign extension
        z_ok  = (&z_top) | ~(|z_top);
        b_ok  = (&b_top) | ~(|b_top);
        use_zero = z_ok;
        fits_any = z_ok | b_ok;
        delta    = z_ok ? word[DELTA_W-1:0] : diff[DELTA_W-1:0];
    end
endmodule

// File: rtl/bdi_compressor.sv
module bdi_compressor
    import bdi_pkg::*;
#(
    parameter int WORDS   = 8,
    parameter int WORD_W  = 32,
    parameter int DELTA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [WORDS*WORD_W-1:0] in_line,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [WORDS*WORD_W-1:0] out_data,
    output logic [WORDS-1:0]        out_mask,
    output logic                    out_packed
);
    localparam int LINE_W = WORDS * WORD_W;
    localparam int DSET_W = WORDS * DELTA_W;
    localparam int PAD_W  = LINE_W - WORD_W - DSET_W;

    slot_t cls_st, cls_nx, out_st, out_nx;

    logic [WORDS-1:0]  zsel_c;
    logic [WORDS-1:0]  fit_c;
    logic [DSET_W-1:0] dset_c;

    logic [LINE_W-1:0] cls_line;
    logic [WORDS-1:0]  cls_zsel;
    logic [DSET_W-1:0] cls_dset;
    logic              cls_ok;

    logic out_take;
    logic cls_take;
    logic in_fire;
    logic out_load;

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        bdi_fit_check #(
            .WORD_W (WORD_W),
            .DELTA_W(DELTA_W)
        ) fit_i (
            .word    (in_line[i*WORD_W +: WORD_W]),
            .base    (in_line[WORD_W-1:0]),
            .use_zero(zsel_c[i]),
            .fits_any(fit_c[i]),
            .delta   (dset_c[i*DELTA_W +: DELTA_W])
        );
    end

    always_comb begin
        out_take = (out_st == SLOT_EMPTY) || out_ready;
        cls_take = (cls_st == SLOT_EMPTY) || out_take;
        in_ready = cls_take;
        in_fire  = in_valid && cls_take;
        out_load = out_take && (cls_st == SLOT_FULL);
    end

    always_comb begin
        cls_nx = cls_st;
        unique case (cls_st)
            SLOT_EMPTY: cls_nx = in_valid ? SLOT_FULL : SLOT_EMPTY;
            SLOT_FULL: begin
                if (out_take)
                    cls_nx = in_valid ? SLOT_FULL : SLOT_EMPTY;
            end
            default: cls_nx = SLOT_EMPTY;
        endcase
    end

    always_comb begin
        out_nx = out_st;
        unique case (out_st)
            SLOT_EMPTY: out_nx = (cls_st == SLOT_FULL) ? SLOT_FULL : SLOT_EMPTY;
            SLOT_FULL: begin
                if (out_ready)
                    out_nx = (cls_st == SLOT_FULL) ? SLOT_FULL : SLOT_EMPTY;
            end
            default: out_nx = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cls_st <= SLOT_EMPTY;
            out_st <= SLOT_EMPTY;
        end else begin
            cls_st <= cls_nx;
            out_st <= out_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cls_line <= '0;
            cls_zsel <= '0;
            cls_dset <= '0;
            cls_ok   <= 1'b0;
        end else if (in_fire) begin
            cls_line <= in_line;
            cls_zsel <= zsel_c;
            cls_dset <= dset_c;
            cls_ok   <= &fit_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_data   <= '0;
            out_mask   <= '0;
            out_packed <= 1'b0;
        end else if (out_load) begin
            out_packed <= cls_ok;
            out_mask   <= cls_ok ? cls_zsel : '0;
            out_data   <= cls_ok ? {{PAD_W{1'b0}}, cls_dset, cls_line[WORD_W-1:0]}
                                 : cls_line;
        end
    end

    always_comb out_valid = (out_st == SLOT_FULL);
endmodule

// File: rtl/bdi_expander.sv
module bdi_expander
    import bdi_pkg::*;
#(
    parameter int WORDS   = 8,
    parameter int WORD_W  = 32,
    parameter int DELTA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [WORDS*WORD_W-1:0] in_data,
    input  logic [WORDS-1:0]        in_mask,
    input  logic                    in_packed,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [WORDS*WORD_W-1:0] out_line
);
    localparam int LINE_W = WORDS * WORD_W;
    localparam int EXT_W  = WORD_W - DELTA_W;

    slot_t st, st_nx;
    logic [LINE_W-1:0] rebuilt;
    logic              in_fire;

    for (genvar i = 0; i < WORDS; i++) begin : g_add
        logic [DELTA_W-1:0] d;
        logic [WORD_W-1:0]  sx;
        logic [WORD_W-1:0]  pick;
        always_comb begin
            d    = in_data[WORD_W + i*DELTA_W +: DELTA_W];
            sx   = {{EXT_W{d[DELTA_W-1]}}, d};
            pick = in_mask[i] ? '0 : in_data[WORD_W-1:0];
            rebuilt[i*WORD_W +: WORD_W] = pick + sx;
        end
    end

    always_comb begin
        in_ready = (st == SLOT_EMPTY) || out_ready;
        in_fire  = in_valid && in_ready;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            SLOT_EMPTY: st_nx = in_valid ? SLOT_FULL : SLOT_EMPTY;
            SLOT_FULL: begin
                if (out_ready)
                    st_nx = in_valid ? SLOT_FULL : SLOT_EMPTY;
            end
            default: st_nx = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SLOT_EMPTY;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       out_line <= '0;
        else if (in_fire) out_line <= in_packed ? rebuilt : in_data;
    end

    always_comb out_valid = (st == SLOT_FULL);
endmodule

// File: rtl/bdi_line_codec.sv
module bdi_line_codec #(
    parameter int WORDS   = 8,
    parameter int WORD_W  = 32,
    parameter int DELTA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    c_in_valid,
    output logic                    c_in_ready,
    input  logic [WORDS*WORD_W-1:0] c_in_line,
    output logic                    c_out_valid,
    input  logic                    c_out_ready,
    output logic [WORDS*WORD_W-1:0] c_out_data,
    output logic [WORDS-1:0]        c_out_mask,
    output logic                    c_out_packed,
    input  logic                    d_in_valid,
    output logic                    d_in_ready,
    input  logic [WORDS*WORD_W-1:0] d_in_data,
    input  logic [WORDS-1:0]        d_in_mask,
    input  logic                    d_in_packed,
    output logic                    d_out_valid,
    input  logic                    d_out_ready,
    output logic [WORDS*WORD_W-1:0] d_out_line
);
    bdi_compressor #(
        .WORDS(WORDS), .WORD_W(WORD_W), .DELTA_W(DELTA_W)
    ) comp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (c_in_valid),
        .in_ready  (c_in_ready),
        .in_line   (c_in_line),
        .out_valid (c_out_valid),
        .out_ready (c_out_ready),
        .out_data  (c_out_data),
        .out_mask  (c_out_mask),
        .out_packed(c_out_packed)
    );

    bdi_expander #(
        .WORDS(WORDS), .WORD_W(WORD_W), .DELTA_W(DELTA_W)
    ) exp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (d_in_valid),
        .in_ready (d_in_ready),
        .in_data  (d_in_data),
        .in_mask  (d_in_mask),
        .in_packed(d_in_packed),
        .out_valid(d_out_valid),
        .out_ready(d_out_ready),
        .out_line (d_out_line)
    );
endmodule

// File: rtl/bdi_line_codec_chk.sv
module bdi_line_codec_chk #(
    parameter int WORDS   = 8,
    parameter int WORD_W  = 32,
    parameter int DELTA_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    c_in_ready,
    input logic                    c_out_valid,
    input logic                    c_out_ready,
    input logic [WORDS*WORD_W-1:0] c_out_data,
    input logic [WORDS-1:0]        c_out_mask,
    input logic                    c_out_packed,
    input logic                    d_in_ready,
    input logic                    d_out_valid,
    input logic                    d_out_ready,
    input logic [WORDS*WORD_W-1:0] d_out_line
);
    localparam int LINE_W = WORDS * WORD_W;
    localparam int HDR_W  = WORD_W + WORDS * DELTA_W;

    // R10
    c_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_out_valid && !c_out_ready |=> c_out_valid && $stable(c_out_data)
            && $stable(c_out_mask) && $stable(c_out_packed));

    // R10
    d_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        d_out_valid && !d_out_ready |=> d_out_valid && $stable(d_out_line));

    // R4
    raw_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_out_valid && !c_out_packed |-> c_out_mask == '0);

    // R3
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_out_valid && c_out_packed |-> c_out_data[LINE_W-1:HDR_W] == '0);

    // R3
    base_delta_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_out_valid && c_out_packed && !c_out_mask[0]
            |-> c_out_data[WORD_W +: DELTA_W] == '0);

    // R11
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_idle_chk: assert (!c_out_valid && !d_out_valid && c_in_ready && d_in_ready);
        end
    end
endmodule

bind bdi_line_codec bdi_line_codec_chk #(
    .WORDS(WORDS), .WORD_W(WORD_W), .DELTA_W(DELTA_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .c_in_ready  (c_in_ready),
    .c_out_valid (c_out_valid),
    .c_out_ready (c_out_ready),
    .c_out_data  (c_out_data),
    .c_out_mask  (c_out_mask),
    .c_out_packed(c_out_packed),
    .d_in_ready  (d_in_ready),
    .d_out_valid (d_out_valid),
    .d_out_ready (d_out_ready),
    .d_out_line  (d_out_line)
);

// File: tb/bdi_line_codec_tb_top.sv
`timescale 1ns/1ps
module bdi_line_codec_tb_top;
    localparam int LW = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          c_in_valid = 1'b0, c_in_ready;
    logic [LW-1:0] c_in_line = '0;
    logic          c_out_valid, c_out_ready = 1'b1;
    logic [LW-1:0] c_out_data;
    logic [7:0]    c_out_mask;
    logic          c_out_packed;
    logic          d_in_valid = 1'b0, d_in_ready;
    logic [LW-1:0] d_in_data = '0;
    logic [7:0]    d_in_mask = '0;
    logic          d_in_packed = 1'b0;
    logic          d_out_valid, d_out_ready = 1'b1;
    logic [LW-1:0] d_out_line;

    bdi_line_codec dut_i (
        .clk(clk), .rst_n(rst_n),
        .c_in_valid(c_in_valid), .c_in_ready(c_in_ready), .c_in_line(c_in_line),
        .c_out_valid(c_out_valid), .c_out_ready(c_out_ready), .c_out_data(c_out_data),
        .c_out_mask(c_out_mask), .c_out_packed(c_out_packed),
        .d_in_valid(d_in_valid), .d_in_ready(d_in_ready), .d_in_data(d_in_data),
        .d_in_mask(d_in_mask), .d_in_packed(d_in_packed),
        .d_out_valid(d_out_valid), .d_out_ready(d_out_ready), .d_out_line(d_out_line)
    );

    typedef struct {
        logic [LW-1:0] data;
        logic [7:0]    mask;
        logic          pk;
        string         tag;
        bit            lat;
        int            t0;
    } exp_t;

    exp_t cq[$];
    exp_t dq[$];
    int   n_run = 0;
    int   n_fail = 0;
    int   cyc = 0;
    bit   rnd_rdy = 1'b0;
    bit   done = 1'b0;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_run++; n_fail++;
            $display("FAIL R10 watchdog: actual %0d cycles expected fewer than 100000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    always @(posedge clk) begin
        #1;
        c_out_ready = rnd_rdy ? ($urandom % 3 != 0) : 1'b1;
        d_out_ready = rnd_rdy ? ($urandom % 3 != 0) : 1'b1;
    end

    function automatic logic [31:0] sx8(logic [7:0] b);
        return {{24{b[7]}}, b};
    endfunction

    function automatic exp_t model_c(logic [LW-1:0] ln);
        exp_t e;
        logic [31:0] b, w, df;
        logic [63:0] ds;
        bit ok;
        b = ln[31:0]; ok = 1'b1; ds = '0; e.mask = '0;
        for (int i = 0; i < 8; i++) begin
            w  = ln[i*32 +: 32];
            df = w - b;
            if ($signed(w) >= -128 && $signed(w) <= 127) begin
                e.mask[i] = 1'b1; ds[i*8 +: 8] = w[7:0];
            end else if ($signed(df) >= -128 && $signed(df) <= 127) begin
                ds[i*8 +: 8] = df[7:0];
            end else ok = 1'b0;
        end
        e.pk   = ok;
        e.data = ok ? {160'd0, ds, b} : ln;
        if (!ok) e.mask = '0;
        return e;
    endfunction

    task automatic send_c(logic [LW-1:0] ln, string tag, bit lat);
        exp_t e;
        e = model_c(ln); e.tag = tag; e.lat = lat;
        @(negedge clk);
        c_in_valid = 1'b1; c_in_line = ln;
        while (!c_in_ready) @(negedge clk);
        e.t0 = cyc;
        cq.push_back(e);
        @(negedge clk);
        c_in_valid = 1'b0;
    endtask

    task automatic send_d(logic [LW-1:0] dt, logic [7:0] mk, logic pk,
                          logic [LW-1:0] want, string tag, bit lat);
        exp_t e;
        e.data = want; e.mask = '0; e.pk = 1'b0; e.tag = tag; e.lat = lat;
        @(negedge clk);
        d_in_valid = 1'b1; d_in_data = dt; d_in_mask = mk; d_in_packed = pk;
        while (!d_in_ready) @(negedge clk);
        e.t0 = cyc;
        dq.push_back(e);
        @(negedge clk);
        d_in_valid = 1'b0;
    endtask

    task automatic round_trip(logic [LW-1:0] ln, string tag);
        exp_t m;
        m = model_c(ln);
        send_d(m.data, m.mask, m.pk, ln, tag, 1'b0);
    endtask

    always @(negedge clk) begin
        if (rst_n && c_out_valid && c_out_ready) begin
            exp_t e;
            n_run++;
            if (cq.size() == 0) begin
                n_fail++;
                $display("FAIL R10 unexpected compressor output: actual %h expected none", c_out_data);
            end else begin
                e = cq.pop_front();
                if (c_out_data !== e.data || c_out_mask !== e.mask || c_out_packed !== e.pk) begin
                    n_fail++;
                    $display("FAIL %s compress: actual %h/%h/%b expected %h/%h/%b",
                             e.tag, c_out_data, c_out_mask, c_out_packed, e.data, e.mask, e.pk);
                end
                if (e.lat) begin
                    n_run++;
                    if (cyc - e.t0 != 2) begin
                        n_fail++;
                        $display("FAIL R6 latency: actual %0d expected 2", cyc - e.t0);
                    end
                end
            end
        end
        if (rst_n && d_out_valid && d_out_ready) begin
            exp_t e;
            n_run++;
            if (dq.size() == 0) begin
                n_fail++;
                $display("FAIL R10 unexpected expander output: actual %h expected none", d_out_line);
            end else begin
                e = dq.pop_front();
                if (d_out_line !== e.data) begin
                    n_fail++;
                    $display("FAIL %s expand: actual %h expected %h", e.tag, d_out_line, e.data);
                end
                if (e.lat) begin
                    n_run++;
                    if (cyc - e.t0 != 1) begin
                        n_fail++;
                        $display("FAIL R9 latency: actual %0d expected 1", cyc - e.t0);
                    end
                end
            end
        end
    end

    initial begin
        logic [31:0] bs;
        logic [LW-1:0] mix, bad1, bad2, zp, rl, arb, arb_exp;
        logic [7:0] am;
        repeat (3) @(negedge clk);
        // R11 reset state
        n_run++;
        if (c_out_valid !== 1'b0 || d_out_valid !== 1'b0 || c_in_ready !== 1'b1 || d_in_ready !== 1'b1) begin
            n_fail++;
            $display("FAIL R11 reset: actual %b%b%b%b expected 0011",
                     c_out_valid, d_out_valid, c_in_ready, d_in_ready);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        bs  = 32'h1000_0000;
        mix = {bs - 32'd1, 32'h0000_007F, bs + 32'd127, 32'hFFFF_FF80,
               bs - 32'd128, 32'h0000_0003, bs + 32'd5, bs};
        bad1 = mix; bad1[5*32 +: 32] = bs + 32'd128;
        bad2 = mix; bad2[3*32 +: 32] = bs - 32'd129;
        zp  = {32'd9, 32'hFFFF_FFF0, 32'd100, 32'd0, 32'd1, 32'hFFFF_FF80, 32'd127, 32'd16};

        // directed, idle path, ready high: values and latency
        send_c('0, "R5", 1'b1);
        repeat (3) @(negedge clk);
        send_c({8{32'h1234_5678}}, "R5", 1'b1);
        repeat (3) @(negedge clk);
        send_c(mix, "R1", 1'b1);
        send_c(mix, "R3", 1'b0);
        send_c(bad1, "R4", 1'b0);
        send_c(bad2, "R4", 1'b0);
        send_c(zp, "R2", 1'b0);
        repeat (4) @(negedge clk);

        send_d({160'd0, 64'h0102_FF80_7F00_0305, 32'hABCD_0000}, 8'h00, 1'b1,
               {32'hABCD_0001, 32'hABCD_0002, 32'hABCC_FFFF, 32'hABCC_FF80,
                32'hABCD_007F, 32'hABCD_0000, 32'hABCD_0003, 32'hABCD_0005}, "R7", 1'b1);
        repeat (3) @(negedge clk);
        round_trip(mix, "R7");
        round_trip(zp, "R7");
        round_trip('0, "R7");
        rl = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        send_d(rl, 8'hA5, 1'b0, rl, "R8", 1'b1);
        repeat (4) @(negedge clk);

        // R7 arbitrary mask on a packed item
        arb = {160'd0, 64'h80_7F_01_FF_10_20_30_40, 32'h8000_0010};
        am  = 8'b1010_0110;
        for (int i = 0; i < 8; i++)
            arb_exp[i*32 +: 32] = (am[i] ? 32'd0 : 32'h8000_0010) + sx8(arb[32 + i*8 +: 8]);
        send_d(arb, am, 1'b1, arb_exp, "R7", 1'b0);

        // R10 random back-pressure with mixed traffic
        rnd_rdy = 1'b1;
        fork
            for (int k = 0; k < 30; k++) begin
                logic [LW-1:0] ln;
                logic [31:0] b;
                b = $urandom;
                for (int i = 0; i < 8; i++)
                    ln[i*32 +: 32] = (k % 3 == 0) ? $urandom
                                   : (k % 3 == 1) ? b + sx8(8'($urandom))
                                                  : sx8(8'($urandom));
                send_c(ln, "R10", 1'b0);
            end
            for (int k = 0; k < 30; k++) begin
                logic [LW-1:0] ln;
                logic [31:0] b;
                b = $urandom;
                for (int i = 0; i < 8; i++)
                    ln[i*32 +: 32] = (k % 2 == 0) ? b + sx8(8'($urandom)) : $urandom;
                round_trip(ln, "R10");
            end
        join
        rnd_rdy = 1'b0;
        for (int w = 0; w < 200 && (cq.size() != 0 || dq.size() != 0); w++) @(negedge clk);
        n_run++;
        if (cq.size() != 0 || dq.size() != 0) begin
            n_fail++;
            $display("FAIL R10 lost items: actual %0d/%0d pending expected 0/0", cq.size(), dq.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule